// File: doc/BRIEF.md
# Single-Cycle Word Load/Store Processor Core

This block is a small 32-bit processor that completes one instruction per clock. A program counter register drives an instruction fetch port. The fetched word is decoded, operands are read from a 32-entry register file, and an adder/subtractor/shifter produces either a result or an effective address. On the same clock edge the result is written back, a store is committed, and the program counter takes its next value.

Both memory ports are one word wide and byte-addressed. The instruction memory and the data memory are outside the block. They are expected to answer reads combinationally within the cycle: the core reads `fetch_data` and `ld_data` in the same cycle that it presents the address. Only whole-word loads and stores are supported.

Ten operations are recognised: add, subtract, add-immediate, shift-left-logical, load word, store word, branch-if-equal, branch-if-not-equal, absolute jump and jump-to-register. Any other encoding is retired as a no-op.

Top module: `lsw_cpu`

## Requirements
- R1: While `rst` is high, and on the first edge with `rst` high, the program counter (`fetch_addr`) becomes RESET_PC (default 0x00400000). Each non-control instruction advances it by 4.
- R2: With instruction bits [31:26] equal to 0, the remaining fields are rs [25:21], rt [20:16], rd [15:11], shamt [10:6] and funct [5:0]. funct 32 writes rs+rt into rd, and funct 34 writes rs-rt into rd.
- R3: Opcode 8 writes rs plus the sign-extended 16-bit field [15:0] into rt.
- R4: Register 0 always reads as zero. A write aimed at register 0 has no effect.
- R5: Opcode 35 (load) and opcode 43 (store) use rs plus the sign-extended immediate as the byte address. A load writes `ld_data` into rt. A store raises `st_en` for that one cycle, with `st_data` equal to rt.
- R6: Opcode 4 branches when rs equals rt, and opcode 5 branches when they differ. The branch target is PC+4 plus the sign-extended immediate shifted left by 2. Otherwise the PC goes to PC+4.
- R7: Opcode 2 jumps to {PC+4[31:28], bits [25:0], 2'b00}.
- R8: Opcode 0 with funct 8 loads the PC from register rs.
- R9: Opcode 0 with funct 0 writes rt shifted left by shamt into rd.
- R10: Any other opcode or funct writes no register, raises no store, and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_addr | output | 32 | Byte address of the current instruction (the PC) |
| fetch_data | input | 32 | Instruction word at `fetch_addr` |
| ls_addr | output | 32 | Byte address for a load or store |
| st_data | output | 32 | Word to be stored |
| st_en | output | 1 | Store strobe, one cycle per store |
| ld_data | input | 32 | Word read from `ls_addr` |

## Verification
The hardest situation to reach from the ports is a register write that must not happen. Writes to register 0, instructions skipped by a taken branch or jump, and unrecognised encodings all leave no trace unless the affected register is later copied out. The stimulus therefore primes each target register with a known value, places the instruction that must not write, and then stores that register to data memory, where the bench compares the word. A counted backward loop and a jump-to-register whose target is built from a shift and an add exercise the PC paths with values that cannot be reached by straight-line fetch.

// File: rtl/lsw_pkg.sv
package lsw_pkg;
  localparam int XLEN   = 32;
  localparam int RA_W   = 5;
  localparam int NREG   = 1 << RA_W;
  localparam int IMM_W  = 16;
  localparam int JADR_W = 26;

  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_JUMP  = 6'd2;
  localparam logic [5:0] OP_BREQ  = 6'd4;
  localparam logic [5:0] OP_BRNE  = 6'd5;
  localparam logic [5:0] OP_ADDI  = 6'd8;
  localparam logic [5:0] OP_LOAD  = 6'd35;
  localparam logic [5:0] OP_STORE = 6'd43;

  localparam logic [5:0] FN_SHL   = 6'd0;
  localparam logic [5:0] FN_JREG  = 6'd8;
  localparam logic [5:0] FN_ADD   = 6'd32;
  localparam logic [5:0] FN_SUB   = 6'd34;

  typedef enum logic [1:0] {CALC_ADD, CALC_SUB, CALC_SHL} calc_e;
  typedef enum logic [2:0] {PC_STEP, PC_IFEQ, PC_IFNE, PC_FAR, PC_REG} pcsel_e;

  typedef struct packed {
    logic   wr_en;
    logic   dst_rd;
    logic   b_imm;
    logic   from_mem;
    logic   store;
    calc_e  calc;
    pcsel_e pcsel;
  } ctl_t;
endpackage

// File: rtl/lsw_decode.sv
module lsw_decode
  import lsw_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] fn,
  output ctl_t       ctl
);
  always_comb begin
    ctl = '{wr_en: 1'b0, dst_rd: 1'b0, b_imm: 1'b0, from_mem: 1'b0,
            store: 1'b0, calc: CALC_ADD, pcsel: PC_STEP};
    unique case (op)
      OP_RTYPE: begin
        unique case (fn)
          FN_ADD:  begin ctl.wr_en = 1'b1; ctl.dst_rd = 1'b1; end
          FN_SUB:  begin ctl.wr_en = 1'b1; ctl.dst_rd = 1'b1; ctl.calc = CALC_SUB; end
          FN_SHL:  begin ctl.wr_en = 1'b1; ctl.dst_rd = 1'b1; ctl.calc = CALC_SHL; end
          FN_JREG: ctl.pcsel = PC_REG;
          default: ;
        endcase
      end
      OP_ADDI:  begin ctl.wr_en = 1'b1; ctl.b_imm = 1'b1; end
      OP_LOAD:  begin ctl.wr_en = 1'b1; ctl.b_imm = 1'b1; ctl.from_mem = 1'b1; end
      OP_STORE: begin ctl.b_imm = 1'b1; ctl.store = 1'b1; end
      OP_BREQ:  ctl.pcsel = PC_IFEQ;
      OP_BRNE:  ctl.pcsel = PC_IFNE;
      OP_JUMP:  ctl.pcsel = PC_FAR;
      default: ;
    endcase
  end
endmodule

// File: rtl/lsw_regfile.sv
module lsw_regfile #(
  parameter int W    = 32,
  parameter int DEPTH = 32,
  localparam int AW  = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  output logic [W-1:0]  qa,
  output logic [W-1:0]  qb
);
  logic [W-1:0] store_q [DEPTH];

  // Entry 0 is never written; its read is forced to zero as well.
  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) store_q[waddr] <= wdata;
  end

  assign qa = (ra == '0) ? '0 : store_q[ra];
  assign qb = (rb == '0) ? '0 : store_q[rb];
endmodule

// File: rtl/lsw_calc.sv
module lsw_calc
  import lsw_pkg::*;
#(
  parameter int W = 32,
  localparam int SW = $clog2(W)
) (
  input  calc_e         op,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic [SW-1:0] sh,
  output logic [W-1:0]  y,
  output logic          same
);
  always_comb begin
    unique case (op)
      CALC_SUB: y = a - b;
      CALC_SHL: y = b << sh;
      default:  y = a + b;
    endcase
  end
  assign same = (a == b);
endmodule

// File: rtl/lsw_cpu.sv
module lsw_cpu
  import lsw_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0040_0000
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] fetch_addr,
  input  logic [31:0] fetch_data,
  output logic [31:0] ls_addr,
  output logic [31:0] st_data,
  output logic        st_en,
  input  logic [31:0] ld_data
);
  localparam int SH_W = $clog2(XLEN);

  logic [XLEN-1:0] pc_q, pc_nx, pc_inc, br_tgt, far_tgt;
  logic [5:0]      f_op, f_fn;
  logic [RA_W-1:0] f_rs, f_rt, f_rd;
  logic [SH_W-1:0] f_sh;
  logic [IMM_W-1:0] f_imm;
  logic [JADR_W-1:0] f_far;
  logic [XLEN-1:0] imm_x, rs_val, rt_val, calc_b, calc_y, wb_val;
  logic            calc_same;
  logic            rf_we;
  logic [RA_W-1:0] rf_waddr;
  ctl_t            ctl;

  assign f_op  = fetch_data[31:26];
  assign f_rs  = fetch_data[25:21];
  assign f_rt  = fetch_data[20:16];
  assign f_rd  = fetch_data[15:11];
  assign f_sh  = fetch_data[10:6];
  assign f_fn  = fetch_data[5:0];
  assign f_imm = fetch_data[15:0];
  assign f_far = fetch_data[25:0];

  lsw_decode u_dec (.op(f_op), .fn(f_fn), .ctl(ctl));

  assign imm_x = {{(XLEN-IMM_W){f_imm[IMM_W-1]}}, f_imm};

  assign rf_we    = ctl.wr_en;
  assign rf_waddr = ctl.dst_rd ? f_rd : f_rt;
  assign wb_val   = ctl.from_mem ? ld_data : calc_y;

  lsw_regfile #(.W(XLEN), .DEPTH(NREG)) u_rf (
    .clk(clk), .we(rf_we), .waddr(rf_waddr), .wdata(wb_val),
    .ra(f_rs), .rb(f_rt), .qa(rs_val), .qb(rt_val)
  );

  assign calc_b = ctl.b_imm ? imm_x : rt_val;

  lsw_calc #(.W(XLEN)) u_calc (
    .op(ctl.calc), .a(rs_val), .b(calc_b), .sh(f_sh),
    .y(calc_y), .same(calc_same)
  );

  assign pc_inc  = pc_q + XLEN'(4);
  assign br_tgt  = pc_inc + {imm_x[XLEN-3:0], 2'b00};
  assign far_tgt = {pc_inc[XLEN-1:XLEN-4], f_far, 2'b00};

  always_comb begin
    unique case (ctl.pcsel)
      PC_IFEQ: pc_nx = calc_same  ? br_tgt : pc_inc;
      PC_IFNE: pc_nx = !calc_same ? br_tgt : pc_inc;
      PC_FAR:  pc_nx = far_tgt;
      PC_REG:  pc_nx = rs_val;
      default: pc_nx = pc_inc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC;
    else     pc_q <= pc_nx;
  end

  assign fetch_addr = pc_q;
  assign ls_addr    = calc_y;
  assign st_data    = rt_val;
  assign st_en      = ctl.store & ~rst;
endmodule

// File: rtl/lsw_cpu_checker.sv
module lsw_cpu_checker (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic        st_en,
  input logic [31:0] ls_addr,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val,
  input logic        rf_we
);
  logic [5:0]  op, fn;
  logic [31:0] sx, seq, btgt;
  logic        plain, known;

  assign op    = instr[31:26];
  assign fn    = instr[5:0];
  assign sx    = {{16{instr[15]}}, instr[15:0]};
  assign seq   = pc + 32'd4;
  assign btgt  = seq + (sx << 2);
  assign plain = (op == 6'd0 && (fn == 6'd0 || fn == 6'd32 || fn == 6'd34))
              || op == 6'd8 || op == 6'd35 || op == 6'd43;
  assign known = plain || op == 6'd2 || op == 6'd4 || op == 6'd5
              || (op == 6'd0 && fn == 6'd8);

  a_r1_step: assert property (@(posedge clk) disable iff (rst)
    plain |=> pc == $past(seq));

  a_r4_zero_reads: assert property (@(posedge clk) disable iff (rst)
    (instr[25:21] == 5'd0) |-> rs_val == 32'd0);

  a_r5_store_addr: assert property (@(posedge clk) disable iff (rst)
    st_en |-> (op == 6'd43 && ls_addr == rs_val + sx));

  a_r6_beq_taken: assert property (@(posedge clk) disable iff (rst)
    (op == 6'd4 && rs_val == rt_val) |=> pc == $past(btgt));

  a_r6_bne_fall: assert property (@(posedge clk) disable iff (rst)
    (op == 6'd5 && rs_val == rt_val) |=> pc == $past(seq));

  a_r7_far: assert property (@(posedge clk) disable iff (rst)
    (op == 6'd2) |=> pc == {$past(seq[31:28]), $past(instr[25:0]), 2'b00});

  a_r8_reg_jump: assert property (@(posedge clk) disable iff (rst)
    (op == 6'd0 && fn == 6'd8) |=> pc == $past(rs_val));

  a_r10_unknown_quiet: assert property (@(posedge clk) disable iff (rst)
    !known |-> (!st_en && !rf_we));

  a_r10_unknown_step: assert property (@(posedge clk) disable iff (rst)
    !known |=> pc == $past(seq));
endmodule

bind lsw_cpu lsw_cpu_checker u_lsw_chk (
  .clk(clk), .rst(rst), .pc(fetch_addr), .instr(fetch_data),
  .st_en(st_en), .ls_addr(ls_addr), .rs_val(rs_val), .rt_val(rt_val),
  .rf_we(rf_we)
);

// File: tb/test_lsw_cpu.sv
module test_lsw_cpu;
  localparam logic [31:0] BASE = 32'h0040_0000;
  localparam int NDM = 10;
  localparam logic [31:0] EXP_DM [NDM] = '{
    32'hFFFF_FFFE, 32'd12, 32'd40, 32'd0, 32'd13,
    32'd2, 32'd6, 32'd9, 32'd3, 32'd5 };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fetch_addr, fetch_data, ls_addr, st_data, ld_data;
  logic        st_en;
  logic [31:0] prog [64];
  logic [31:0] dm [16];
  int          checks = 0, errors = 0, stores = 0;

  always #2.5 clk = ~clk;

  lsw_cpu i_lsw_cpu (
    .clk(clk), .rst(rst), .fetch_addr(fetch_addr), .fetch_data(fetch_data),
    .ls_addr(ls_addr), .st_data(st_data), .st_en(st_en), .ld_data(ld_data)
  );

  logic [31:0] widx;
  assign widx       = (fetch_addr - BASE) >> 2;
  assign fetch_data = (widx < 64) ? prog[widx[5:0]] : 32'd0;
  assign ld_data    = dm[ls_addr[5:2]];

  always @(posedge clk) begin
    if (st_en) begin
      dm[ls_addr[5:2]] <= st_data;
      stores <= stores + 1;
    end
  end

  function automatic logic [31:0] r_ins(int rs, int rt, int rd, int sh, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction
  function automatic logic [31:0] i_ins(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string tag_of(int i);
    case (i)
      0: return "R2 R3 add with negative immediate";
      1: return "R2 sub";
      2: return "R9 sll";
      3: return "R4 write to register 0";
      4: return "R5 load then addi";
      5: return "R6 beq skip and bne fall-through";
      6: return "R7 R10 jump skip and unknown no-op";
      7: return "R8 jump to register";
      8: return "R6 backward loop";
      default: return "R5 negative store offset";
    endcase
  endfunction

  initial begin
    for (int i = 0; i < 64; i++) prog[i] = 32'd0;
    for (int i = 0; i < 16; i++) dm[i] = 32'hDEAD_BEEF;
    prog[0]  = i_ins(8, 0, 1, 5);
    prog[1]  = i_ins(8, 1, 2, -12);
    prog[2]  = r_ins(1, 2, 3, 0, 32);
    prog[3]  = r_ins(1, 2, 4, 0, 34);
    prog[4]  = r_ins(0, 1, 5, 3, 0);
    prog[5]  = i_ins(43, 0, 3, 0);
    prog[6]  = i_ins(43, 0, 4, 4);
    prog[7]  = i_ins(43, 0, 5, 8);
    prog[8]  = i_ins(8, 0, 0, 77);
    prog[9]  = i_ins(43, 0, 0, 12);
    prog[10] = i_ins(35, 0, 6, 4);
    prog[11] = i_ins(8, 6, 7, 1);
    prog[12] = i_ins(43, 0, 7, 16);
    prog[13] = i_ins(8, 0, 8, 1);
    prog[14] = i_ins(4, 1, 1, 1);
    prog[15] = i_ins(8, 0, 8, 99);
    prog[16] = i_ins(5, 1, 1, 1);
    prog[17] = i_ins(8, 8, 8, 1);
    prog[18] = i_ins(43, 0, 8, 20);
    prog[19] = i_ins(8, 0, 9, 40);
    prog[20] = i_ins(43, 9, 1, -4);
    prog[21] = i_ins(8, 0, 10, 6);
    prog[22] = r_ins(0, 0, 10, 0, 63);
    prog[23] = {6'd2, 26'h010_001A};
    prog[24] = i_ins(8, 0, 10, 1);
    prog[25] = i_ins(8, 0, 10, 2);
    prog[26] = i_ins(43, 0, 10, 24);
    prog[27] = i_ins(8, 0, 12, 9);
    prog[28] = i_ins(8, 0, 11, 16'h40);
    prog[29] = r_ins(0, 11, 11, 16, 0);
    prog[30] = i_ins(8, 11, 11, 16'h84);
    prog[31] = r_ins(11, 0, 0, 0, 8);
    prog[32] = i_ins(8, 0, 12, 1);
    prog[33] = i_ins(43, 0, 12, 28);
    prog[34] = i_ins(8, 0, 14, 3);
    prog[35] = i_ins(8, 0, 13, 0);
    prog[36] = i_ins(8, 13, 13, 1);
    prog[37] = i_ins(5, 13, 14, -2);
    prog[38] = i_ins(43, 0, 13, 32);
    prog[39] = i_ins(4, 0, 0, -1);

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset PC", fetch_addr, BASE);
    check("R1 no store during reset", {31'd0, st_en}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 sequential step", fetch_addr, BASE + 32'd4);
    repeat (120) @(negedge clk);

    for (int i = 0; i < NDM; i++) check(tag_of(i), dm[i], EXP_DM[i]);
    check("R10 R6 R7 R8 store count", stores, 32'd10);
    check("R6 halt loop PC", fetch_addr, BASE + 32'd156);

    rst = 1'b1;
    @(negedge clk);
    check("R1 PC after second reset", fetch_addr, BASE);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #5000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule